// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block sits on the host side of a byte-wide asynchronous static memory. It takes single-beat read and write requests on a valid/ready handshake and drives the 19-bit address, the 8-bit data bus (split into output, output-enable and input) and the active-low chip, write and output enables. Every strobe phase lasts a whole number of clock cycles. These counts come from nanosecond timing parameters: each figure is divided by the clock period, rounded up, and never allowed to fall below one cycle.

A read keeps write enable high and drives chip enable and output enable low. It holds them for the longest of the address access time, the output-enable access time and the read cycle time. The data bus is captured on the last cycle and returned with a one-cycle done pulse. A write first raises output enable. It then lowers chip enable and write enable together, which opens the write window, and drives data for the whole window. Only one strobe closes the window, and a parameter chooses which one. The data is held for one more cycle while the other strobe is still low. A recovery period follows, and its length depends on which strobe closed the window.

A write-protect input stops new requests from being accepted. If the abort option is on, raising it also forces every strobe inactive at once during a transfer. That transfer then ends without a done pulse.

Top module: `nvsram_ctrl`

## Requirements
- R1: After reset, chip, write and output enables are high. The data driver is off, done is low and ready is high.
- R2: A read drives write enable high and chip and output enable low. With default parameters at a 20 ns clock this lasts 5 cycles. The data bus is sampled on the last of those cycles and shown on the read-data output while done is high. Done rises in the 6th cycle after the accepting edge.
- R3: During a write, output enable stays high. Chip and write enable are both low for at least 4 cycles. Address, write data and the data driver stay constant and on throughout that window.
- R4: With write enable as the closing strobe (default), write enable rises first. Chip enable stays low and data stays driven for one more cycle. Write enable then stays high for at least one cycle before ready returns, which is the 7th cycle after the accepting edge.
- R5: The data driver is never on while output enable is low. After a read it turns on no sooner than 2 cycles after output enable rises.
- R6: Ready is high only when the controller is idle and write-protect is low. A request is taken on a clock edge where valid and ready are both high. After a read, ready returns in the 8th cycle after the accepting edge.
- R7: While write-protect is high and the controller is idle, no request is accepted and all strobes stay high. Memory contents are left unchanged.
- R8: If write-protect rises during an active read or write phase, all strobes go high and the data driver goes off in that same cycle. No done pulse follows, and an aborted write does not change memory.
- R9: Each completed request gives exactly one done pulse, one cycle wide. For a write it comes after the write window has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Request byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Read data, valid with done |
| wp_i | input | 1 | Write-protect lockout |
| mem_addr_o | output | 19 | Memory address bus |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 8 | Data from memory |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |

## Verification
The hardest case to reach from the ports is write-protect rising partway through a write window. A correct design must cut the window short without committing data or giving a done pulse. The stimulus starts a write, waits two cycles, raises write-protect between clock edges and checks the strobes straight away. It then reads the location back to confirm the old value is still there. The memory model only returns stored data once the read strobes have been held for the full access time, so a capture one cycle early shows up as wrong data. A read followed at once by a write exercises the bus-turnaround rule.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACT,
    ST_RD_REC,
    ST_WR_PULSE,
    ST_WR_TAIL,
    ST_WR_REC
  } nvs_state_e;

  // ceiling division, at least one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/nvs_dpath.sv
module nvs_dpath #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (cap_i) begin
      rdata_o <= mem_dq_i;
    end
  end

endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int unsigned N_RD        = 5,
  parameter int unsigned N_HZ        = 2,
  parameter int unsigned N_WP        = 4,
  parameter int unsigned N_REC       = 1,
  parameter int unsigned TW          = 8,
  parameter bit          TERM_CE     = 1'b0,
  parameter bit          ABORT_ON_WP = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic          wp_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          accept_o,
  output logic          cap_o,
  output logic          done_o,
  output logic          ready_o,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic          dq_oe_o
);

  nvs_state_e state_q, state_d;
  logic active, abort, gate, done_set;
  logic ce_n, we_n, oe_n, dq_oe;
  logic tail_ce_n, tail_we_n;

  assign active   = (state_q == ST_RD_ACT) || (state_q == ST_WR_PULSE) || (state_q == ST_WR_TAIL);
  assign gate     = ABORT_ON_WP && wp_i;
  assign abort    = gate && active;
  assign ready_o  = (state_q == ST_IDLE) && !wp_i;
  assign accept_o = req_valid_i && ready_o;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    cap_o      = 1'b0;
    done_set   = 1'b0;
    if (abort) begin
      tmr_load_o = 1'b1;
      if (state_q == ST_RD_ACT) begin
        state_d   = ST_RD_REC;
        tmr_val_o = TW'(N_HZ - 1);
      end else begin
        state_d   = ST_WR_REC;
        tmr_val_o = TW'(N_REC - 1);
      end
    end else begin
      case (state_q)
        ST_IDLE: if (accept_o) begin
          tmr_load_o = 1'b1;
          if (req_write_i) begin
            state_d   = ST_WR_PULSE;
            tmr_val_o = TW'(N_WP - 1);
          end else begin
            state_d   = ST_RD_ACT;
            tmr_val_o = TW'(N_RD - 1);
          end
        end
        ST_RD_ACT: if (tmr_zero_i) begin
          state_d    = ST_RD_REC;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(N_HZ - 1);
          cap_o      = 1'b1;
          done_set   = 1'b1;
        end
        ST_RD_REC: if (tmr_zero_i) state_d = ST_IDLE;
        ST_WR_PULSE: if (tmr_zero_i) begin
          state_d    = ST_WR_TAIL;
          tmr_load_o = 1'b1;
          tmr_val_o  = '0;
        end
        ST_WR_TAIL: if (tmr_zero_i) begin
          state_d    = ST_WR_REC;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(N_REC - 1);
          done_set   = 1'b1;
        end
        ST_WR_REC: if (tmr_zero_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_set;
    end
  end

  // closing strobe rises first, the other one follows a cycle later
  if (TERM_CE) begin : g_term_ce
    assign tail_ce_n = 1'b1;
    assign tail_we_n = 1'b0;
  end else begin : g_term_we
    assign tail_ce_n = 1'b0;
    assign tail_we_n = 1'b1;
  end

  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    case (state_q)
      ST_RD_ACT: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_WR_PULSE: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        dq_oe = 1'b1;
      end
      ST_WR_TAIL: begin
        ce_n  = tail_ce_n;
        we_n  = tail_we_n;
        dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

  assign ce_n_o  = ce_n | gate;
  assign we_n_o  = we_n | gate;
  assign oe_n_o  = oe_n | gate;
  assign dq_oe_o = dq_oe & ~gate;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ABORT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ABORT_ON_WP && wp_i && active) |=> !done_o); // R8

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter int unsigned DW          = 8,
  parameter int unsigned CLK_NS      = 20,
  parameter int unsigned T_RC        = 100,
  parameter int unsigned T_WC        = 100,
  parameter int unsigned T_WP        = 75,
  parameter int unsigned T_DS        = 40,
  parameter int unsigned T_ACC       = 100,
  parameter int unsigned T_OEA       = 50,
  parameter int unsigned T_OHZ       = 35,
  parameter int unsigned T_WR_WE     = 5,
  parameter int unsigned T_WR_CE     = 20,
  parameter int unsigned TW          = 8,
  parameter bit          TERM_CE     = 1'b0,
  parameter bit          ABORT_ON_WP = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic          wp_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no
);

  localparam int unsigned N_RD   = umax(umax(ns2cyc(T_ACC, CLK_NS), ns2cyc(T_OEA, CLK_NS)),
                                        ns2cyc(T_RC, CLK_NS));
  localparam int unsigned N_HZ   = ns2cyc(T_OHZ, CLK_NS);
  localparam int unsigned N_WP   = umax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DS, CLK_NS));
  localparam int unsigned N_WCYC = ns2cyc(T_WC, CLK_NS);
  localparam int unsigned N_WRR  = TERM_CE ? ns2cyc(T_WR_CE, CLK_NS) : ns2cyc(T_WR_WE, CLK_NS);
  // pad recovery so pulse + tail + recovery covers the write cycle time
  localparam int unsigned N_WCL  = (N_WCYC > N_WP + 1) ? (N_WCYC - N_WP - 1) : 1;
  localparam int unsigned N_REC  = umax(N_WRR, N_WCL);

  logic          tmr_load, tmr_zero, accept, cap;
  logic [TW-1:0] tmr_val;

  nvs_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  nvs_seq #(
    .N_RD(N_RD), .N_HZ(N_HZ), .N_WP(N_WP), .N_REC(N_REC), .TW(TW),
    .TERM_CE(TERM_CE), .ABORT_ON_WP(ABORT_ON_WP)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .wp_i        (wp_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept),
    .cap_o       (cap),
    .done_o      (rsp_done_o),
    .ready_o     (req_ready_o),
    .ce_n_o      (mem_ce_no),
    .we_n_o      (mem_we_no),
    .oe_n_o      (mem_oe_no),
    .dq_oe_o     (mem_dq_oe_o)
  );

  nvs_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .cap_i      (cap),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rsp_rdata_o)
  );

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no); // R3
  AST_DRIVE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !mem_we_no) |-> mem_dq_oe_o); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !mem_we_no) |=> (mem_ce_no || mem_we_no || $stable(mem_addr_o))); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no); // R5

endmodule

// File: tb/nvsram_ctrl_test.sv
module nvsram_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, wp = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n;
  logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvsram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata), .wp_i(wp),
    .mem_addr_o(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n), .mem_oe_no(mem_oe_n)
  );

  // behavioural memory with timing monitors
  logic [7:0]  mem [0:1023];
  logic        win_q = 1'b0, dqoe_q = 1'b0;
  logic [18:0] w_addr = '0;
  logic [7:0]  w_data = '0;
  int wcnt = 0, rd_cnt = 0, oe_hi = 0;
  int err_short = 0, err_addr = 0, err_data = 0, err_oe = 0, err_turn = 0, err_cont = 0;
  logic win, rd_act;

  assign win    = !mem_ce_n && !mem_we_n;
  assign rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = (rd_act && rd_cnt >= 4) ? mem[mem_addr[9:0]] : 8'hEE;

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (win) begin
      if (!win_q) begin
        w_addr = mem_addr;
        w_data = mem_dq_o;
        wcnt   = 1;
      end else begin
        wcnt++;
        if (mem_addr != w_addr) err_addr++;
        if (mem_dq_o != w_data) err_data++;
      end
      if (!mem_oe_n || !mem_dq_oe) err_oe++;
    end else if (win_q) begin
      if (wcnt >= 4) mem[w_addr[9:0]] = w_data;
      else if (!wp) err_short++;
    end
    if (mem_dq_oe && !dqoe_q && oe_hi < 2) err_turn++;
    if (mem_dq_oe && !mem_oe_n) err_cont++;
    rd_cnt = rd_act ? rd_cnt + 1 : 0;
    oe_hi  = mem_oe_n ? ((oe_hi < 100) ? oe_hi + 1 : oe_hi) : 0;
    win_q  = win;
    dqoe_q = mem_dq_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic start_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
  endtask

  task automatic read_op(input logic [18:0] a, input logic [7:0] exp);
    int dk = -1;
    logic [7:0] got = 8'h00;
    start_req(1'b0, a, 8'h00);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        check(!mem_ce_n && !mem_oe_n && mem_we_n, "R2 read strobes",
              {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
      end
      if (dk > 0 && k == dk + 1) check(!rsp_done, "R9 done width", rsp_done, 0);
      if (rsp_done && dk < 0) begin
        dk  = k;
        got = rsp_rdata;
      end
      if (k == 7) check(!req_ready, "R6 ready busy", req_ready, 0);
      if (k == 8) check(req_ready, "R6 ready after read", req_ready, 1);
    end
    check(dk == 6, "R2 done latency", dk, 6);
    check(got == exp, "R2 read data", got, exp);
  endtask

  task automatic write_op(input logic [18:0] a, input logic [7:0] d);
    int dk = -1;
    start_req(1'b1, a, d);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        check(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe, "R3 write strobes",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
        check(mem_addr == a && mem_dq_o == d, "R3 addr/data", {mem_addr, mem_dq_o}, {a, d});
      end
      if (k == 5) check(mem_we_n && !mem_ce_n && mem_dq_oe, "R4 tail",
                        {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
      if (k == 6) check(mem_we_n && mem_ce_n && !mem_dq_oe && !req_ready, "R4 recovery",
                        {mem_ce_n, mem_we_n, mem_dq_oe, req_ready}, 4'b1100);
      if (rsp_done && dk < 0) dk = k;
      if (k == 7) check(req_ready, "R4 ready after write", req_ready, 1);
    end
    check(dk == 6, "R9 write done", dk, 6);
  endtask

  task automatic t_reset;
    check(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done,
          "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done},
          6'b111100);
  endtask

  task automatic t_basic;
    write_op(19'h00012, 8'h5A);
    read_op(19'h00012, 8'h5A);
    write_op(19'h7FFFF, 8'hA5);
    read_op(19'h7FFFF, 8'hA5);
    read_op(19'h00100, 8'h00);
  endtask

  task automatic t_turnaround;
    read_op(19'h00012, 8'h5A);
    write_op(19'h00200, 8'h3C);
    write_op(19'h00201, 8'hC3);
    read_op(19'h00200, 8'h3C);
    check(err_turn == 0 && err_cont == 0, "R5 bus turnaround", err_turn + err_cont, 0);
  endtask

  task automatic t_wp_idle;
    int strobe_bad = 0, rdy_bad = 0;
    @(negedge clk);
    wp = 1'b1;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 19'h00200;
    req_wdata = 8'hFF;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (req_ready) rdy_bad++;
      if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_oe) strobe_bad++;
    end
    req_valid = 1'b0;
    wp = 1'b0;
    check(rdy_bad == 0, "R7 no ready under wp", rdy_bad, 0);
    check(strobe_bad == 0, "R7 strobes idle under wp", strobe_bad, 0);
    read_op(19'h00200, 8'h3C);
  endtask

  task automatic t_abort_write;
    int dn = 0;
    start_req(1'b1, 19'h00201, 8'h99);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    wp = 1'b1;
    #1;
    check(mem_ce_n && mem_we_n && !mem_dq_oe, "R8 write abort strobes",
          {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b110);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (rsp_done) dn++;
    end
    wp = 1'b0;
    check(dn == 0, "R8 no done on abort", dn, 0);
    read_op(19'h00201, 8'hC3);
  endtask

  task automatic t_abort_read;
    int dn = 0;
    start_req(1'b0, 19'h00012, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    wp = 1'b1;
    #1;
    check(mem_ce_n && mem_oe_n, "R8 read abort strobes", {mem_ce_n, mem_oe_n}, 2'b11);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (rsp_done) dn++;
    end
    wp = 1'b0;
    check(dn == 0, "R8 no done on read abort", dn, 0);
    read_op(19'h00012, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_turnaround();
    t_wp_idle();
    t_abort_write();
    t_abort_read();
    check(err_short == 0 && err_oe == 0, "R3 window length/oe", err_short + err_oe, 0);
    check(err_addr == 0 && err_data == 0, "R3 window stability", err_addr + err_data, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule